// File: doc/BRIEF.md
# PWM Timer Channel with Capture and Event Counting

This block is a single channel of a motor-drive PWM timer. A timer counter (TC) counts from zero up to a programmed limit and then wraps. A programmed match value splits each period in two. While TC is at or above the match value, the A output is active. The B output always drives the opposite level. Only edge-aligned operation exists.

Three external event inputs come in asynchronously and are synchronised to the clock. Any edge that is enabled on any input is a capture event. A capture event stores the present TC value and can raise an interrupt flag. It can also end the current period early, in the same way that reaching the limit does. A mode bit lets TC step on synchronised edges of one chosen event input instead of on every clock. The waveform and capture logic do not change in that mode.

Software programs the channel through a plain register port. Writes take one clock and reads are combinational. No part of the block carries streaming data, so it has no valid/ready handshake and none of its pins can apply back-pressure.

Top module: `pwmcap_top`

## Requirements
- R1: A capture event copies the value TC held just before that clock edge into the capture register (address 5, read only).
- R2: A capture event sets the interrupt flag (`irq`, address 6 bit 0) only if the control bit irq_en (address 0 bit 3) is 1. While that bit is 0, a capture leaves the flag at 0.
- R3: When the control bit rst_on_cap (address 0 bit 2) is 1, a capture event does the same as a limit hit: TC goes to 0, `out_a` goes passive (0 for a nonzero match), and `out_b` goes to 1.
- R4: When the control bit ext_count (address 0 bit 1) is 1, TC steps only on selected synchronised edges of the chosen event input. Clock cycles with no such edge leave TC unchanged.
- R5: In counter mode, address 0 bits 5:4 pick the input (0 to 2; a value of 3 picks none). Address 0 bits 7:6 pick the edge: 01 rising, 10 falling, 11 both, 00 none. Edges on any other input do not move TC.
- R6: In counter mode, the match/limit waveform and capture behave exactly as they do in timer mode.
- R7: Each event input passes through two synchronising flops and one edge flop. A change that is set up before clock edge k takes effect at edge k+2 and no earlier.
- R8: When run (address 0 bit 0) is 1 and the mode is timer mode, TC counts 0 up to the limit (address 2) and then wraps to 0. `out_a` is 1 exactly while TC is at or above the match value (address 3, nonzero), and `out_b` is its complement.
- R9: Address 1 bits 2:0 enable rising-edge capture on inputs 0 to 2. Bits 5:3 enable falling-edge capture on those inputs. An edge that is not enabled causes no capture.
- R10: Writing 1 to address 6 bit 0 clears the flag. A capture that sets the flag in the same cycle wins, and the flag stays 1.
- R11: After reset, TC, the capture register and all control fields are 0, the flag is 0, `out_a` is 0 and `out_b` is 1. Address 4 reads TC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational |
| ev_in | input | 3 | Asynchronous external event inputs |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B, complement of A |
| irq | output | 1 | Capture interrupt flag |

## Verification
The hardest case to reach from the ports is a capture that sets the flag in the same clock cycle as a software clear of that flag. The synchroniser delays the event by exactly two edges, so the stimulus changes the event input and then issues the clear write so that it lands on the second edge after that. Capture values need to be predictable, so those tests run in counter mode with the clock-driven count stopped and move TC only by hand-made edges. A capture then records a known count, and the reset-on-capture test can look at TC and both outputs in the cycle that follows.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;
  typedef enum logic [2:0] {
    ADR_CTRL   = 3'd0,
    ADR_CAPSEL = 3'd1,
    ADR_LIMIT  = 3'd2,
    ADR_MATCH  = 3'd3,
    ADR_TC     = 3'd4,
    ADR_CAPV   = 3'd5,
    ADR_FLAG   = 3'd6
  } reg_addr_e;

  typedef enum logic [1:0] {
    EDG_NONE = 2'b00,
    EDG_RISE = 2'b01,
    EDG_FALL = 2'b10,
    EDG_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic [1:0] cnt_edge;
    logic [1:0] cnt_src;
    logic       irq_en;
    logic       rst_on_cap;
    logic       ext_count;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwmcap_sync.sv
module pwmcap_sync #(
  parameter int N_IN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] din,
  output logic [N_IN-1:0] rise,
  output logic [N_IN-1:0] fall
);
  localparam int STAGES = 3;

  for (genvar g = 0; g < N_IN; g++) begin : g_ch
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], din[g]};
    end
    assign rise[g] = sh[STAGES-2] & ~sh[STAGES-1];
    assign fall[g] = ~sh[STAGES-2] & sh[STAGES-1];

    assert_single_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> !rise[g]);
    assert_single_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fall[g] |=> !fall[g]);
  end
endmodule

// File: rtl/pwmcap_core.sv
module pwmcap_core #(
  parameter int TC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ext_count,
  input  logic            cnt_pulse,
  input  logic            cap_restart,
  input  logic [TC_W-1:0] limit,
  input  logic [TC_W-1:0] match,
  output logic [TC_W-1:0] tc,
  output logic            out_a
);
  logic            step;
  logic            lim_hit;
  logic            period_end;
  logic [TC_W-1:0] tc_nxt;

  assign step       = run & (ext_count ? cnt_pulse : 1'b1);
  assign lim_hit    = step && (tc == limit);
  assign period_end = lim_hit | cap_restart;
  assign tc_nxt     = tc + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc    <= '0;
      out_a <= 1'b0;
    end else if (period_end) begin
      tc    <= '0;
      out_a <= (match == '0);
    end else if (step) begin
      tc <= tc_nxt;
      if (tc_nxt == match) out_a <= 1'b1;
    end
  end

  assert_wrap_at_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lim_hit |=> (tc == '0));
  assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_restart |=> (tc == '0));
  assert_hold_without_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !cap_restart) |=> $stable(tc));
  assert_passive_after_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && match != '0) |=> !out_a);
endmodule

// File: rtl/pwmcap_capture.sv
module pwmcap_capture #(
  parameter int TC_W = 16,
  parameter int N_IN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] rise,
  input  logic [N_IN-1:0] fall,
  input  logic [N_IN-1:0] rise_en,
  input  logic [N_IN-1:0] fall_en,
  input  logic [TC_W-1:0] tc,
  input  logic            irq_en,
  input  logic            clr,
  output logic            cap_event,
  output logic [TC_W-1:0] cap_val,
  output logic            flag
);
  logic flag_set;

  assign cap_event = |((rise & rise_en) | (fall & fall_en));
  assign flag_set  = cap_event & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cap_val <= '0;
    else if (cap_event) cap_val <= tc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (flag_set) flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  assert_capture_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event |=> (cap_val == $past(tc)));
  assert_flag_only_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !(cap_event && irq_en)) |=> !flag);
  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_event && irq_en && clr) |=> flag);
  assert_clear_works_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !cap_event) |=> !flag);
endmodule

// File: rtl/pwmcap_top.sv
module pwmcap_top
  import pwmcap_pkg::*;
#(
  parameter int TC_W = 16,
  parameter int N_IN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [TC_W-1:0] wr_data,
  input  logic [2:0]      rd_addr,
  output logic [TC_W-1:0] rd_data,
  input  logic [N_IN-1:0] ev_in,
  output logic            out_a,
  output logic            out_b,
  output logic            irq
);
  localparam int SEL_W = 2 * N_IN;

  ctrl_t             ctrl;
  logic [SEL_W-1:0]  capsel;
  logic [TC_W-1:0]   limit;
  logic [TC_W-1:0]   match;
  logic [TC_W-1:0]   tc;
  logic [TC_W-1:0]   cap_val;
  logic [N_IN-1:0]   rise;
  logic [N_IN-1:0]   fall;
  logic              cap_event;
  logic              cnt_pulse;
  logic              clr;
  logic              a_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      capsel <= '0;
      limit  <= '0;
      match  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL:   ctrl   <= ctrl_t'(wr_data[CTRL_W-1:0]);
        ADR_CAPSEL: capsel <= wr_data[SEL_W-1:0];
        ADR_LIMIT:  limit  <= wr_data;
        ADR_MATCH:  match  <= wr_data;
        default: ;
      endcase
    end
  end

  assign clr = wr_en && (wr_addr == ADR_FLAG) && wr_data[0];

  always_comb begin
    cnt_pulse = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (ctrl.cnt_src == 2'(i))
        cnt_pulse = (rise[i] & ctrl.cnt_edge[0]) | (fall[i] & ctrl.cnt_edge[1]);
    end
  end

  pwmcap_sync #(.N_IN(N_IN)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ev_in),
    .rise (rise),
    .fall (fall)
  );

  pwmcap_capture #(.TC_W(TC_W), .N_IN(N_IN)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .fall     (fall),
    .rise_en  (capsel[N_IN-1:0]),
    .fall_en  (capsel[SEL_W-1:N_IN]),
    .tc       (tc),
    .irq_en   (ctrl.irq_en),
    .clr      (clr),
    .cap_event(cap_event),
    .cap_val  (cap_val),
    .flag     (irq)
  );

  pwmcap_core #(.TC_W(TC_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl.run),
    .ext_count  (ctrl.ext_count),
    .cnt_pulse  (cnt_pulse),
    .cap_restart(cap_event & ctrl.rst_on_cap),
    .limit      (limit),
    .match      (match),
    .tc         (tc),
    .out_a      (a_int)
  );

  assign out_a = a_int;
  assign out_b = ~a_int;

  always_comb begin
    case (rd_addr)
      ADR_CTRL:   rd_data = TC_W'(ctrl);
      ADR_CAPSEL: rd_data = TC_W'(capsel);
      ADR_LIMIT:  rd_data = limit;
      ADR_MATCH:  rd_data = match;
      ADR_TC:     rd_data = tc;
      ADR_CAPV:   rd_data = cap_val;
      ADR_FLAG:   rd_data = TC_W'(irq);
      default:    rd_data = '0;
    endcase
  end

  assert_counter_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.ext_count && !cnt_pulse && !cap_event) |=> $stable(tc));
endmodule

// File: tb/pwmcap_tb.sv
module pwmcap_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [2:0]  ev_in = '0;
  logic        out_a, out_b, irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] v;

  always #4 clk = ~clk;

  pwmcap_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ev_in(ev_in),
    .out_a(out_a), .out_b(out_b), .irq(irq)
  );

  // match, limit, clock cycles to run
  localparam int unsigned VEC [6][3] = '{
    '{3, 7, 5}, '{3, 7, 2}, '{4, 4, 4}, '{4, 4, 5}, '{2, 5, 13}, '{9, 5, 8}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; ev_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic set_ev(input int idx, input logic val);
    @(negedge clk);
    ev_in[idx] = val;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    @(negedge clk);
    rd(3'd4, v); chk("R11 tc", v, 0);
    rd(3'd5, v); chk("R11 capval", v, 0);
    rd(3'd0, v); chk("R11 ctrl", v, 0);
    chk("R11 out_a", out_a, 0);
    chk("R11 out_b", out_b, 1);
    chk("R11 irq", irq, 0);

    // R8 timer-mode table
    for (int i = 0; i < 6; i++) begin
      int m, l, n, etc, ea;
      m = VEC[i][0]; l = VEC[i][1]; n = VEC[i][2];
      etc = n % (l + 1);
      ea  = (m <= l && etc >= m) ? 1 : 0;
      do_reset();
      wr(3'd2, 16'(l));
      wr(3'd3, 16'(m));
      wr(3'd0, 16'h0001);
      repeat (n) @(posedge clk);
      @(negedge clk);
      rd(3'd4, v);
      chk("R8 tc", v, etc);
      chk("R8 out_a", out_a, ea);
      chk("R8 out_b", out_b, 1 - ea);
    end

    // R4/R5/R6 counter mode, edge codes rise(01)=3, fall(10)=2, both(11)=5
    for (int e = 1; e < 4; e++) begin
      int exp_c;
      exp_c = (e == 1) ? 3 : (e == 2) ? 2 : 5;
      do_reset();
      wr(3'd2, 16'd100);
      wr(3'd3, 16'd2);
      wr(3'd0, 16'(3 + (1 << 4) + (e << 6)));
      set_ev(1, 1); set_ev(1, 0); set_ev(1, 1); set_ev(1, 0); set_ev(1, 1);
      rd(3'd4, v); chk("R5 edge select count", v, exp_c);
      chk("R6 out_a in counter mode", out_a, 1);
      repeat (20) @(negedge clk);
      rd(3'd4, v); chk("R4 no clock counting", v, exp_c);
      set_ev(0, 1); set_ev(0, 0);
      rd(3'd4, v); chk("R5 other input ignored", v, exp_c);
    end

    // capture path, counter mode rising on input 1
    do_reset();
    wr(3'd2, 16'd100);
    wr(3'd3, 16'd2);
    wr(3'd0, 16'd83);
    wr(3'd1, 16'd4);            // R9 rise capture on input 2
    set_ev(1, 1); set_ev(1, 0); set_ev(1, 1);   // tc = 2
    // R7 latency
    @(negedge clk); ev_in[2] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rd(3'd5, v); chk("R7 not before edge k+2", v, 0);
    @(posedge clk);
    @(negedge clk); rd(3'd5, v); chk("R1 capture value", v, 2);
    chk("R2 flag stays low when disabled", irq, 0);
    set_ev(1, 0); set_ev(1, 1);                 // tc = 3
    set_ev(2, 0);
    rd(3'd5, v); chk("R9 falling not enabled", v, 2);
    wr(3'd0, 16'd91);                           // irq_en
    set_ev(2, 1);
    rd(3'd5, v); chk("R1 capture value 2", v, 3);
    chk("R2 flag set when enabled", irq, 1);
    wr(3'd6, 16'd1);
    chk("R10 clear", irq, 0);
    set_ev(2, 0);
    // R10 same-cycle set and clear
    @(negedge clk); ev_in[2] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd6; wr_data = 16'd1;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
    chk("R10 set wins over clear", irq, 1);
    wr(3'd6, 16'd1);
    chk("R10 clear again", irq, 0);

    // R9 falling capture on input 0
    wr(3'd1, 16'd8);
    set_ev(0, 1);
    rd(3'd5, v); chk("R9 rise on input 0 ignored", v, 3);
    set_ev(1, 0); set_ev(1, 1);                 // tc = 4
    set_ev(0, 0);
    rd(3'd5, v); chk("R9 fall capture", v, 4);
    chk("R9 irq", irq, 1);

    // R3 reset on capture
    wr(3'd0, 16'd87);
    wr(3'd1, 16'd4);
    set_ev(2, 0);
    chk("R6 out_a before restart", out_a, 1);
    set_ev(2, 1);
    rd(3'd4, v); chk("R3 tc cleared", v, 0);
    chk("R3 out_a passive", out_a, 0);
    chk("R3 out_b", out_b, 1);
    rd(3'd5, v); chk("R3 capval", v, 4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule